// File: doc/BRIEF.md
# Receiver Control Registers with Output Override Logic

This block keeps two 12-bit receiver configuration words that are written through a simple parallel write port, with a strobe, a 6-bit address and 12 data bits. It turns the fields of these words into the receiver's control outputs. These are the VCO enable, the transmit buffer enable, the LNA enable, a one-cycle start pulse for the DC-offset correction engine, the clock-input selects and the phase-trim code. It also drives two general-purpose output pins.

Each general-purpose pin is chosen by a fixed priority of sources. The highest is a remap that applies while the DC-correction window is open. Next is a remap that applies while the transmit pin is high. Next, for the first pin only, is a test-signal multiplexer. Last are the plain register bits. DC correction can be started in two ways: by a start bit that clears itself, or by each rising edge of the receive-enable pin. The receive-enable pin is asynchronous and passes through a two-flop synchronizer before it is used.

Top module: `rxcfg_ctrl`

## Requirements
- R1: After synchronous reset (rst_n low at a clock edge), the first word is 12'h004 and the second word is 12'h400. So the VCO follows the receive enable, the transmit buffer follows tx_en_in, edge-triggered DC start is armed, both general-purpose pins are 0, lna_en is 1 and dcc_start is 0.
- R2: A write with wr_en high at address 6'b100000 loads the first word, and at 6'b100001 loads the second word. A write to any other address changes no output. The first word's bits 10:7 drive iq_phase_cal, bit 6 drives clk_dc_coupled and bit 5 drives clk_div2_en. Bit 11 of the first word and bit 6 of the second word have no effect.
- R3: When bit 4 of the first word is 0, vco_en equals the synchronized rx_en_in, two clocks late. When bit 4 is 1, vco_en equals bit 3 of the first word.
- R4: When bit 2 of the first word is 1, txbuf_en equals tx_en_in. When bit 2 is 0, txbuf_en equals tx_cfg_bit.
- R5: When bit 9 of the second word is 1 and dcc_window is high, lna_en is 0. Otherwise lna_en is 1.
- R6: Bits 1:0 of the first word select the GPO1 test source. 00 passes the lower-priority value through. 01 selects shift_tap, 10 selects vcocal_msb and 11 selects adapt_cnt2.
- R7: Each GPO pin takes the first source that applies, in this order. (a) When bit 8 of the second word is 1 and dcc_window is high, GPO1 takes bit 4 and GPO2 takes bit 5. (b) When bit 7 is 1 and tx_en_in is high, GPO1 takes bit 2 and GPO2 takes bit 3. (c) For GPO1 only, a non-zero test select picks the test source. (d) Otherwise the pins take the normal bits, given in R8.
- R8: With no override active, gpo1 equals bit 0 and gpo2 equals bit 1 of the second word.
- R9: Writing bit 11 of the second word as 1 sets a pending start. The start stays pending while the synchronized receive enable is low. In the first clock where it is high, dcc_start pulses and the pending bit clears.
- R10: When bit 10 of the second word is 1, each rising edge of the synchronized receive enable produces a dcc_start pulse. An edge on rx_en_in at clock edge A gives dcc_start high from edge A+2 to edge A+3. When bit 10 is 0, edges produce no pulse.
- R11: If the start bit and a receive-enable edge trigger in the same clock, dcc_start is a single one-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 6 | Write address |
| wr_data | input | 12 | Write data |
| rx_en_in | input | 1 | Receive enable pin, asynchronous |
| tx_en_in | input | 1 | Transmit enable pin |
| tx_cfg_bit | input | 1 | Alternate transmit buffer enable from the wider configuration |
| dcc_window | input | 1 | High while DC correction is running |
| shift_tap | input | 1 | Serial data tap used as a test source |
| vcocal_msb | input | 1 | VCO calibration counter MSB, used as a test source |
| adapt_cnt2 | input | 1 | Adapt counter output, used as a test source |
| vco_en | output | 1 | VCO enable |
| txbuf_en | output | 1 | Transmit buffer enable |
| lna_en | output | 1 | LNA enable |
| dcc_start | output | 1 | One-cycle DC correction start pulse |
| gpo1 | output | 1 | General-purpose output 1 |
| gpo2 | output | 1 | General-purpose output 2 |
| iq_phase_cal | output | 4 | I/Q phase trim code |
| clk_dc_coupled | output | 1 | Clock input coupling select |
| clk_div2_en | output | 1 | Clock input divide-by-two enable |

## Verification
The GPO pins, lna_en, txbuf_en, the clock selects and a register-sourced vco_en are combinational from the stored words and the pins. They change in the clock after a write, or in the same cycle as an input change. vco_en, when it follows the receive enable, lags rx_en_in by two clocks. dcc_start rises two clocks after a rising edge of rx_en_in, or one clock after a start bit becomes pending with the synchronized enable already high. The bench drives inputs on the falling edge and compares all outputs one time unit later against a reference model. That model is advanced at each rising edge with the same register and synchronizer delays, so every expected value is sampled in the cycle it is due.

// File: rtl/rxcfg_pkg.sv
// Package: shared widths, addresses, reset words and field layouts for the
// receiver control block. Assumes 6-bit addresses and 12-bit data words.
package rxcfg_pkg;
    localparam int ADDR_W = 6;
    localparam int WORD_W = 12;

    localparam logic [ADDR_W-1:0] ADDR_CFG1 = 6'b100000;
    localparam logic [ADDR_W-1:0] ADDR_CFG2 = 6'b100001;

    // Test source select for GPO1
    typedef enum logic [1:0] {
        TST_PASS   = 2'b00,
        TST_SHIFT  = 2'b01,
        TST_VCOCAL = 2'b10,
        TST_ADAPT  = 2'b11
    } tst_sel_e;

    // First word, bits 10:0 (bit 11 reserved, not stored)
    typedef struct packed {
        logic [3:0] iq_phase;  // 10:7
        logic       clk_dc;    // 6
        logic       clk_div2;  // 5
        logic       vco_sel;   // 4
        logic       vco_on;    // 3
        logic       tx_sel;    // 2
        tst_sel_e   tst;       // 1:0
    } cfg1_t;

    // Second word, bits 11:7 and 5:0 (bit 6 reserved, not stored)
    typedef struct packed {
        logic       dc_st;     // 11
        logic       dc_en;     // 10
        logic       lna_blank; // 9
        logic       trd;       // 8
        logic       trtx_en;   // 7
        logic [1:0] trd_gpo;   // 5:4
        logic [1:0] trtx_gpo;  // 3:2
        logic [1:0] gpo_norm;  // 1:0
    } cfg2_t;

    localparam cfg1_t CFG1_RST = cfg1_t'(11'h004);
    localparam cfg2_t CFG2_RST = cfg2_t'(11'h200);
endpackage

// File: rtl/rxcfg_regfile.sv
// Module: storage for the two configuration words.
// Decodes the write address and keeps only the defined fields.
// The start bit clears when st_ack reports it consumed; a write in the
// same cycle wins over the clear. Assumes synchronous active-low reset.
module rxcfg_regfile
    import rxcfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              st_ack,
    output cfg1_t             cfg1_q,
    output cfg2_t             cfg2_q
);
    logic hit1;
    logic hit2;

    // Address decode for both words
    always_comb begin
        hit1 = wr_en && (wr_addr == ADDR_CFG1);
        hit2 = wr_en && (wr_addr == ADDR_CFG2);
    end

    // First word: plain load
    always_ff @(posedge clk) begin
        if (!rst_n)    cfg1_q <= CFG1_RST;
        else if (hit1) cfg1_q <= cfg1_t'(wr_data[10:0]);
    end

    // Second word: load, or self-clear of the start bit once consumed
    always_ff @(posedge clk) begin
        if (!rst_n)        cfg2_q <= CFG2_RST;
        else if (hit2)     cfg2_q <= cfg2_t'({wr_data[11:7], wr_data[5:0]});
        else if (st_ack)   cfg2_q.dc_st <= 1'b0;
    end

    // R2
    wrong_addr_keeps_cfg1_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr != ADDR_CFG1) |=> $stable(cfg1_q));

    // R9
    start_bit_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_ack && !(hit2 && wr_data[11])) |=> !cfg2_q.dc_st);
endmodule

// File: rtl/rxcfg_dcc_start.sv
// Module: receive-enable synchronizer and DC-correction start pulse.
// Synchronizes the asynchronous enable through SYNC_STAGES flops, then
// detects its rising edge. Merges the edge (when armed) with a pending
// start bit into one registered, single-cycle pulse. Assumes
// SYNC_STAGES >= 2 and synchronous active-low reset.
module rxcfg_dcc_start #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_en_async,
    input  logic edge_arm,
    input  logic st_pend,
    output logic rx_en_sync,
    output logic st_ack,
    output logic start_pulse
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   rx_prev_q;
    logic                   rx_rise;

    // Synchronizer chain for the receive enable
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], rx_en_async};
    end

    assign rx_en_sync = sync_q[SYNC_STAGES-1];

    // Previous synchronized value, for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) rx_prev_q <= 1'b0;
        else        rx_prev_q <= rx_en_sync;
    end

    // Rising edge and start-bit consumption
    always_comb begin
        rx_rise = rx_en_sync && !rx_prev_q;
        st_ack  = st_pend && rx_en_sync;
    end

    // Registered start pulse from either source
    always_ff @(posedge clk) begin
        if (!rst_n) start_pulse <= 1'b0;
        else        start_pulse <= (rx_rise && edge_arm) || st_ack;
    end

    // R10
    edge_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rx_en_sync) && edge_arm) |=> start_pulse);

    // R9
    pend_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_pend && rx_en_sync) |=> start_pulse);

    // R10
    no_start_unarmed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_pend && !edge_arm) |=> !start_pulse);
endmodule

// File: rtl/rxcfg_gpo_mux.sv
// Module: general-purpose output selection.
// Each pin takes the first source that applies: the DC-window remap, then
// the transmit remap, then (GPO1 only) the test mux, then the normal bits.
// Purely combinational. Assumes its inputs are synchronous to the clock.
module rxcfg_gpo_mux
    import rxcfg_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  cfg2_t    cfg2,
    input  tst_sel_e tst,
    input  logic     dcc_window,
    input  logic     tx_en,
    input  logic     shift_tap,
    input  logic     vcocal_msb,
    input  logic     adapt_cnt2,
    output logic     gpo1,
    output logic     gpo2
);
    logic dc_remap;
    logic tx_remap;
    logic g1_test;

    // Override qualifiers
    always_comb begin
        dc_remap = cfg2.trd && dcc_window;
        tx_remap = cfg2.trtx_en && tx_en;
    end

    // Test-source multiplexer; pass keeps the normal bit
    always_comb begin
        unique case (tst)
            TST_SHIFT:  g1_test = shift_tap;
            TST_VCOCAL: g1_test = vcocal_msb;
            TST_ADAPT:  g1_test = adapt_cnt2;
            default:    g1_test = cfg2.gpo_norm[0];
        endcase
    end

    // Priority chain for both pins
    always_comb begin
        if (dc_remap) begin
            gpo1 = cfg2.trd_gpo[0];
            gpo2 = cfg2.trd_gpo[1];
        end else if (tx_remap) begin
            gpo1 = cfg2.trtx_gpo[0];
            gpo2 = cfg2.trtx_gpo[1];
        end else begin
            gpo1 = g1_test;
            gpo2 = cfg2.gpo_norm[1];
        end
    end

    // R7
    dc_remap_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg2.trd && dcc_window) |-> (gpo1 == cfg2.trd_gpo[0] && gpo2 == cfg2.trd_gpo[1]));

    // R8
    normal_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(cfg2.trd && dcc_window) && !(cfg2.trtx_en && tx_en) && tst == TST_PASS)
        |-> (gpo1 == cfg2.gpo_norm[0] && gpo2 == cfg2.gpo_norm[1]));
endmodule

// File: rtl/rxcfg_ctrl.sv
// Module: receiver control register block, top level.
// Holds the two configuration words and derives the VCO, transmit buffer,
// LNA, clock-select and GPO outputs, plus the DC-correction start pulse.
// Assumes tx_en_in, dcc_window and the test taps are synchronous to clk;
// rx_en_in may be asynchronous. Synchronous active-low reset.
module rxcfg_ctrl
    import rxcfg_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              rx_en_in,
    input  logic              tx_en_in,
    input  logic              tx_cfg_bit,
    input  logic              dcc_window,
    input  logic              shift_tap,
    input  logic              vcocal_msb,
    input  logic              adapt_cnt2,
    output logic              vco_en,
    output logic              txbuf_en,
    output logic              lna_en,
    output logic              dcc_start,
    output logic              gpo1,
    output logic              gpo2,
    output logic [3:0]        iq_phase_cal,
    output logic              clk_dc_coupled,
    output logic              clk_div2_en
);
    cfg1_t cfg1;
    cfg2_t cfg2;
    logic  rx_sync;
    logic  st_ack;

    rxcfg_regfile u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .st_ack  (st_ack),
        .cfg1_q  (cfg1),
        .cfg2_q  (cfg2)
    );

    rxcfg_dcc_start #(.SYNC_STAGES(SYNC_STAGES)) u_dcc (
        .clk         (clk),
        .rst_n       (rst_n),
        .rx_en_async (rx_en_in),
        .edge_arm    (cfg2.dc_en),
        .st_pend     (cfg2.dc_st),
        .rx_en_sync  (rx_sync),
        .st_ack      (st_ack),
        .start_pulse (dcc_start)
    );

    rxcfg_gpo_mux u_gpo (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg2       (cfg2),
        .tst        (cfg1.tst),
        .dcc_window (dcc_window),
        .tx_en      (tx_en_in),
        .shift_tap  (shift_tap),
        .vcocal_msb (vcocal_msb),
        .adapt_cnt2 (adapt_cnt2),
        .gpo1       (gpo1),
        .gpo2       (gpo2)
    );

    // Enable sources and clock selects
    always_comb begin
        vco_en         = cfg1.vco_sel ? cfg1.vco_on : rx_sync;
        txbuf_en       = cfg1.tx_sel ? tx_en_in : tx_cfg_bit;
        lna_en         = !(cfg2.lna_blank && dcc_window);
        iq_phase_cal   = cfg1.iq_phase;
        clk_dc_coupled = cfg1.clk_dc;
        clk_div2_en    = cfg1.clk_div2;
    end

    // R3
    vco_forced_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg1.vco_sel |-> (vco_en == cfg1.vco_on));

    // R5
    lna_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg2.lna_blank && dcc_window) |-> !lna_en);

    // R11
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dcc_start && !cfg2.dc_st) |=> !dcc_start);
endmodule

// File: tb/rxcfg_ctrl_tb.sv
// Bench: directed corner cases plus seeded random stimulus, compared
// each cycle against a reference model built from the requirements.
module rxcfg_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam logic [5:0] A1 = 6'b100000;
    localparam logic [5:0] A2 = 6'b100001;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [5:0]  wr_addr = '0;
    logic [11:0] wr_data = '0;
    logic        rx_en_in = 1'b0, tx_en_in = 1'b0, tx_cfg_bit = 1'b0;
    logic        dcc_window = 1'b0, shift_tap = 1'b0, vcocal_msb = 1'b0, adapt_cnt2 = 1'b0;
    logic        vco_en, txbuf_en, lna_en, dcc_start, gpo1, gpo2;
    logic [3:0]  iq_phase_cal;
    logic        clk_dc_coupled, clk_div2_en;

    int n_checks = 0;
    int n_fail   = 0;
    int pulses   = 0;

    // reference model state
    logic [11:0] m_r1, m_r2;
    logic        m_s1, m_s2, m_prev, m_start;

    always #(CLK_PERIOD/2) clk = ~clk;

    rxcfg_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rx_en_in(rx_en_in), .tx_en_in(tx_en_in), .tx_cfg_bit(tx_cfg_bit),
        .dcc_window(dcc_window), .shift_tap(shift_tap), .vcocal_msb(vcocal_msb),
        .adapt_cnt2(adapt_cnt2), .vco_en(vco_en), .txbuf_en(txbuf_en), .lna_en(lna_en),
        .dcc_start(dcc_start), .gpo1(gpo1), .gpo2(gpo2), .iq_phase_cal(iq_phase_cal),
        .clk_dc_coupled(clk_dc_coupled), .clk_div2_en(clk_div2_en)
    );

    function automatic logic exp_gpo(input int pin);
        if (m_r2[8] && dcc_window) return pin == 1 ? m_r2[4] : m_r2[5];
        if (m_r2[7] && tx_en_in)   return pin == 1 ? m_r2[2] : m_r2[3];
        if (pin == 2) return m_r2[1];
        case (m_r1[1:0])
            2'b01:   return shift_tap;
            2'b10:   return vcocal_msb;
            2'b11:   return adapt_cnt2;
            default: return m_r2[0];
        endcase
    endfunction

    task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_r1 = 12'h004; m_r2 = 12'h400;
        m_s1 = 0; m_s2 = 0; m_prev = 0; m_start = 0;
    endtask

    // compare, then advance one clock with the model, end at falling edge
    task automatic step(input string tag);
        logic rise, ack;
        #1;
        check({tag, " vco_en (R3)"},   {3'b0, vco_en},   {3'b0, m_r1[4] ? m_r1[3] : m_s2});
        check({tag, " txbuf_en (R4)"}, {3'b0, txbuf_en}, {3'b0, m_r1[2] ? tx_en_in : tx_cfg_bit});
        check({tag, " lna_en (R5)"},   {3'b0, lna_en},   {3'b0, !(m_r2[9] && dcc_window)});
        check({tag, " gpo1 (R7)"},     {3'b0, gpo1},     {3'b0, exp_gpo(1)});
        check({tag, " gpo2 (R7)"},     {3'b0, gpo2},     {3'b0, exp_gpo(2)});
        check({tag, " dcc_start (R10)"}, {3'b0, dcc_start}, {3'b0, m_start});
        check({tag, " iq_phase_cal (R2)"}, iq_phase_cal, m_r1[10:7]);
        check({tag, " clk selects (R2)"}, {2'b0, clk_dc_coupled, clk_div2_en}, {2'b0, m_r1[6], m_r1[5]});
        if (dcc_start) pulses++;
        @(posedge clk);
        if (!rst_n) model_reset();
        else begin
            rise = m_s2 && !m_prev;
            ack  = m_r2[11] && m_s2;
            m_start = (rise && m_r2[10]) || ack;
            m_prev = m_s2; m_s2 = m_s1; m_s1 = rx_en_in;
            if (ack) m_r2[11] = 1'b0;
            if (wr_en && wr_addr == A1) m_r1 = wr_data;
            if (wr_en && wr_addr == A2) m_r2 = wr_data;
        end
        @(negedge clk);
    endtask

    task automatic write(input logic [5:0] a, input logic [11:0] d, input string tag);
        wr_en = 1; wr_addr = a; wr_data = d;
        step(tag);
        wr_en = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired");
        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        model_reset();
        @(negedge clk);
        step("R1 reset held");
        step("R1 reset held");
        rst_n = 1;
        tx_en_in = 1;
        step("R1 after reset");
        step("R1 after reset");

        // R2: unmapped address ignored, then mapped fields
        write(6'b100010, 12'hFFF, "R2 bad address");
        step("R2 bad address");
        write(6'b000001, 12'hFFF, "R2 bad address");
        step("R2 bad address");
        write(A1, 12'hFE4, "R2 clock fields");
        step("R2 clock fields");

        // R3: VCO forced on and off, then back to following rx
        write(A1, 12'h018, "R3 vco forced on");
        rx_en_in = 1; step("R3 vco forced on"); step("R3 vco forced on");
        write(A1, 12'h010, "R3 vco forced off");
        step("R3 vco forced off");
        write(A1, 12'h000, "R3 vco follows rx");
        rx_en_in = 0;
        for (int i = 0; i < 4; i++) step("R3 vco follows rx");
        tx_cfg_bit = 1; tx_en_in = 0; step("R4 cfg bit source");

        // R9: pending start while rx low, fires after rx sync
        write(A2, 12'h800, "R9 start pending");
        for (int i = 0; i < 4; i++) step("R9 start held");
        rx_en_in = 1;
        pulses = 0;
        for (int i = 0; i < 6; i++) step("R9 start fires");
        check("R9 exactly one pulse", pulses[3:0], 4'd1);

        // R10: edge start armed and not armed
        rx_en_in = 0;
        write(A2, 12'h400, "R10 armed");
        for (int i = 0; i < 4; i++) step("R10 armed low");
        rx_en_in = 1; pulses = 0;
        for (int i = 0; i < 6; i++) step("R10 armed edge");
        check("R10 one pulse per edge", pulses[3:0], 4'd1);
        rx_en_in = 0;
        write(A2, 12'h000, "R10 disarmed");
        for (int i = 0; i < 4; i++) step("R10 disarmed low");
        rx_en_in = 1; pulses = 0;
        for (int i = 0; i < 6; i++) step("R10 disarmed edge");
        check("R10 no pulse when disarmed", pulses[3:0], 4'd0);

        // R11: both sources in one cycle
        rx_en_in = 0;
        for (int i = 0; i < 4; i++) step("R11 settle");
        write(A2, 12'hC00, "R11 both sources");
        rx_en_in = 1; pulses = 0;
        for (int i = 0; i < 6; i++) step("R11 both sources");
        check("R11 single pulse", pulses[3:0], 4'd1);

        // R6 / R8: test mux codes, normal bits, and R5 blanking
        write(A2, 12'h202, "R8 normal bits");
        dcc_window = 1; step("R5 lna blank"); dcc_window = 0;
        for (int c = 0; c < 4; c++) begin
            write(A1, 12'(c), "R6 test select");
            for (int k = 0; k < 8; k++) begin
                {shift_tap, vcocal_msb, adapt_cnt2} = 3'(k);
                step("R6 test source");
            end
        end

        // R7 random stimulus
        void'($urandom(32'h5EED_1234));
        for (int i = 0; i < 4000; i++) begin
            logic [31:0] r;
            r = $urandom;
            rx_en_in = r[0]; tx_en_in = r[1]; tx_cfg_bit = r[2]; dcc_window = r[3];
            shift_tap = r[4]; vcocal_msb = r[5]; adapt_cnt2 = r[6];
            wr_en = (r[9:8] == 2'b00);
            wr_addr = r[10] ? (r[11] ? A1 : A2) : 6'($urandom);
            wr_data = 12'($urandom);
            step("R7 random");
        end
        wr_en = 0;

        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule